// File: doc/BRIEF.md
# Synchronized V/F Gated Measurement Counter

This block measures the output of a voltage-to-frequency converter over a fixed window. The timing is taken from the converter's own pulses. A window timer advances on a processor-rate clock enable. It opens its window when an external settling delay ends and closes it after a set number of enabled cycles. Two counters share one gate. One counts converter pulses and the other counts ticks of a fast reference clock enable. The gate opens on the first converter edge inside the window and closes on the first converter edge after the window has ended. Because of this, the reference count is the exact time taken by a whole number of converter periods.

All logic runs on one system clock. The converter input is asynchronous and passes through a flop synchronizer with rising-edge detection. The reference and processor clocks arrive as single-cycle enables. Each measurement is armed by a pulse on the delay input. The rising edge of that input clears the previous result. When the gate closes, a completion flag rises. Software then reads both counts and clears the flag with a read strobe.

Top module: `vfm_gated_counter`

## Requirements
- R1: After reset, `vf_count`, `ref_count` and `meas_done` are all zero.
- R2: While `delay_act` is high no window is open. The window opens in the first cycle after `delay_act` is seen low, and it lasts exactly `WIN_LEN` cycles in which `cpu_ce` is high.
- R3: `vf_in` is synchronized by `SYNC_STAGES` flops (default 2). A rising edge acts on the system clock edge two cycles after the first edge that samples it high. The first such edge acting inside the window opens the gate. That opening edge is not counted.
- R4: The gate closes on the first converter edge that acts after the window has ended. `vf_count` equals the number of converter edges after the opening edge, up to and including the closing edge.
- R5: `ref_count` equals the number of clock edges with `ref_ce` high, from the edge after the opening edge up to and including the closing edge.
- R6: `meas_done` rises on the edge that closes the gate. After that, both counts stay frozen whatever `vf_in` and `ref_ce` do, until the next delay begins.
- R7: If no converter edge acts inside the window, `meas_done` rises when the window ends and both counts stay zero.
- R8: A one-cycle `rd_stb` clears `meas_done` and leaves both counts unchanged.
- R9: A rising edge of `delay_act` clears both counts and `meas_done`. This also applies during a measurement, which is then abandoned.
- R10: Both counters hold at 2^`CNT_W`-1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ce | input | 1 | Fast reference clock enable, one cycle per tick |
| cpu_ce | input | 1 | Processor-rate enable that drives the window timer |
| vf_in | input | 1 | Asynchronous converter pulse input |
| delay_act | input | 1 | High while the settling delay runs; its rise arms a new measurement |
| rd_stb | input | 1 | Read strobe; clears the completion flag |
| vf_count | output | CNT_W | Converter edges counted during the gate |
| ref_count | output | CNT_W | Reference ticks counted during the gate |
| meas_done | output | 1 | Measurement complete |

## Verification
A window timer that is off by one enabled cycle moves the window end. This is shown by stimulus whose converter edges fall a few cycles from that boundary. The pulse count then differs by one when the result is read. A gate register that opens or closes one edge early or late changes both counts at once. A wrong flag register shows in the cycle after the closing edge, after a read strobe, or when a delay arrives. Saturation is seen directly as a count that wraps instead of holding at its maximum.

// File: rtl/vfm_pkg.sv
package vfm_pkg;

    // Measurement sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WINDOW = 2'd2,
        ST_TAIL   = 2'd3
    } vfm_state_e;

    // Control shared by both gated counters
    typedef struct packed {
        logic clr;
        logic vf_inc;
        logic ref_inc;
    } cnt_ctrl_t;

    localparam int DEF_CNT_W   = 24;
    localparam int DEF_WIN_LEN = 100000;
    localparam int DEF_SYNC    = 2;

endpackage

// File: rtl/vfm_sync_edge.sv
module vfm_sync_edge #(
    parameter int SYNC_STAGES = vfm_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    // SYNC_STAGES must be at least 2
    logic [SYNC_STAGES-1:0] sh_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[SYNC_STAGES-2:0], din};
            last_q <= sh_q[SYNC_STAGES-1];
        end
    end

    assign rise = sh_q[SYNC_STAGES-1] & ~last_q;

    // R3
    edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/vfm_window_timer.sv
module vfm_window_timer #(
    parameter int WIN_LEN = vfm_pkg::DEF_WIN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic win_end
);
    localparam int TW = (WIN_LEN > 1) ? $clog2(WIN_LEN + 1) : 1;
    localparam logic [TW-1:0] LAST = TW'(WIN_LEN - 1);

    logic [TW-1:0] cnt_q;

    assign win_end = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (tick && !win_end)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2
    win_single_chk: assert property (@(posedge clk) disable iff (rst)
        win_end |=> !win_end);

    // R2
    win_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/vfm_sat_counter.sv
module vfm_sat_counter #(
    parameter int W = vfm_pkg::DEF_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == MAXV) |=> cnt == MAXV);

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt >= $past(cnt));

endmodule

// File: rtl/vfm_gated_counter.sv
module vfm_gated_counter
    import vfm_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int WIN_LEN     = DEF_WIN_LEN,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_ce,
    input  logic             cpu_ce,
    input  logic             vf_in,
    input  logic             delay_act,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] vf_count,
    output logic [CNT_W-1:0] ref_count,
    output logic             meas_done
);
    vfm_state_e state_q, state_d;
    logic       gate_q, gate_d;
    logic       delay_q, delay_rise;
    logic       vf_edge, win_end, done_set;
    cnt_ctrl_t  ctrl;

    vfm_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (vf_in),
        .rise(vf_edge)
    );

    vfm_window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == ST_WINDOW),
        .tick   (cpu_ce),
        .win_end(win_end)
    );

    assign delay_rise = delay_act & ~delay_q;

    // Sequencer: settle -> window -> tail (gate still open) -> idle
    always_comb begin
        state_d  = state_q;
        gate_d   = gate_q;
        done_set = 1'b0;
        if (delay_act) begin
            state_d = ST_SETTLE;
            gate_d  = 1'b0;
        end else begin
            case (state_q)
                ST_SETTLE: state_d = ST_WINDOW;
                ST_WINDOW: begin
                    if (vf_edge && !gate_q)
                        gate_d = 1'b1;
                    if (win_end) begin
                        if (gate_d)
                            state_d = ST_TAIL;
                        else begin
                            state_d  = ST_IDLE;
                            done_set = 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (vf_edge) begin
                        gate_d   = 1'b0;
                        done_set = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            gate_q    <= 1'b0;
            delay_q   <= 1'b0;
            meas_done <= 1'b0;
        end else begin
            state_q <= state_d;
            gate_q  <= gate_d;
            delay_q <= delay_act;
            if (delay_rise)
                meas_done <= 1'b0;
            else if (done_set)
                meas_done <= 1'b1;
            else if (rd_stb)
                meas_done <= 1'b0;
        end
    end

    always_comb begin
        ctrl.clr     = delay_rise;
        ctrl.vf_inc  = gate_q & vf_edge;
        ctrl.ref_inc = gate_q & ref_ce;
    end

    vfm_sat_counter #(.W(CNT_W)) u_vf_cnt (
        .clk(clk),
        .rst(rst),
        .clr(ctrl.clr),
        .inc(ctrl.vf_inc),
        .cnt(vf_count)
    );

    vfm_sat_counter #(.W(CNT_W)) u_ref_cnt (
        .clk(clk),
        .rst(rst),
        .clr(ctrl.clr),
        .inc(ctrl.ref_inc),
        .cnt(ref_count)
    );

    // R2
    delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
        delay_act |=> state_q == ST_SETTLE && !gate_q);

    // R6
    done_on_close_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_q) && !$past(delay_act)) |-> meas_done);

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate_q && !delay_rise) |=> $stable(vf_count) && $stable(ref_count));

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !done_set) |=> !meas_done);

    // R9
    delay_clear_chk: assert property (@(posedge clk) disable iff (rst)
        delay_rise |=> vf_count == '0 && ref_count == '0 && !meas_done);

endmodule

// File: tb/test_vfm_gated_counter.sv
module test_vfm_gated_counter;
    localparam int CW  = 6;
    localparam int WL  = 20;
    localparam int CAP = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_ce = 1'b0, cpu_ce = 1'b0, vf_in = 1'b0;
    logic          delay_act = 1'b0, rd_stb = 1'b0;
    logic [CW-1:0] vf_count, ref_count;
    logic          meas_done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vfm_gated_counter #(.CNT_W(CW), .WIN_LEN(WL), .SYNC_STAGES(2)) i_vfm_gated_counter (
        .clk(clk), .rst(rst), .ref_ce(ref_ce), .cpu_ce(cpu_ce), .vf_in(vf_in),
        .delay_act(delay_act), .rd_stb(rd_stb),
        .vf_count(vf_count), .ref_count(ref_count), .meas_done(meas_done)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        vf_in = 1'b0; ref_ce = 1'b0; cpu_ce = 1'b0; rd_stb = 1'b0;
    endtask

    // Delay phase: raise for 3 cycles, then release at a negedge (N0)
    task automatic do_delay();
        @(negedge clk);
        idle_inputs();
        delay_act = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 counts cleared (vf)", int'(vf_count), 0);
        check("R9 counts cleared (ref)", int'(ref_count), 0);
        check("R9 done cleared", int'(meas_done), 0);
        delay_act = 1'b0;
    endtask

    // Generic measurement: pulses driven before posedge i act at posedge i+2
    task automatic run_meas(string tag, int first, int period, int cpu_div, int ref_div);
        int w, opn, cls, vf_exp, ref_exp, total, act;
        w = WL * cpu_div;
        opn = -1; cls = -1; vf_exp = 0; ref_exp = 0;
        for (int k = 0; k < 1000 && cls < 0; k++) begin
            act = first + 2 + period * k;
            if (act <= w) begin
                if (opn < 0) opn = act; else vf_exp++;
            end else begin
                if (opn < 0) break;
                cls = act; vf_exp++;
            end
        end
        if (opn < 0) begin
            vf_exp = 0; ref_exp = 0; total = w + 3;
        end else begin
            for (int j = opn + 1; j <= cls; j++)
                if (j % ref_div == 0) ref_exp++;
            total = cls + 3;
        end
        if (vf_exp > CAP) vf_exp = CAP;
        if (ref_exp > CAP) ref_exp = CAP;
        do_delay();
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            cpu_ce = (i % cpu_div == 0);
            ref_ce = (i % ref_div == 0);
            vf_in  = (i >= first) && ((i - first) % period == 0);
        end
        @(negedge clk);
        idle_inputs();
        check({tag, " R4 vf_count"}, int'(vf_count), vf_exp);
        check({tag, " R5 ref_count"}, int'(ref_count), ref_exp);
        check({tag, " R6 done"}, int'(meas_done), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 vf_count", int'(vf_count), 0);
        check("R1 ref_count", int'(ref_count), 0);
        check("R1 done", int'(meas_done), 0);
        rst = 1'b0;
    endtask

    task automatic t_basic();
        run_meas("basic R3", 4, 9, 1, 1);          // expect 2 / 18
    endtask

    task automatic t_ref_half();
        run_meas("ref/2 R5", 4, 9, 1, 2);          // expect 2 / 9
    endtask

    task automatic t_cpu_slow();
        run_meas("cpu/2 R2", 4, 9, 2, 1);          // window 40: expect 4 / 36
    endtask

    task automatic t_odd();
        run_meas("odd R4", 2, 7, 1, 3);            // expect 3 / 7
    endtask

    task automatic t_no_edge();
        run_meas("empty R7", 500, 9, 1, 1);        // expect 0 / 0, done
    endtask

    task automatic t_frozen();
        int v, r;
        run_meas("frz", 4, 9, 1, 1);
        v = int'(vf_count); r = int'(ref_count);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ref_ce = 1'b1;
            vf_in  = (i % 3 == 0);
        end
        @(negedge clk);
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R6 frozen vf", int'(vf_count), v);
        check("R6 frozen ref", int'(ref_count), r);
        check("R6 done held", int'(meas_done), 1);
    endtask

    task automatic t_read();
        run_meas("rd", 4, 9, 1, 1);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R8 done cleared", int'(meas_done), 0);
        check("R8 vf kept", int'(vf_count), 2);
        check("R8 ref kept", int'(ref_count), 18);
    endtask

    task automatic t_abort();
        do_delay();
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            cpu_ce = 1'b1; ref_ce = 1'b1;
            vf_in  = (i >= 4) && ((i - 4) % 9 == 0);
        end
        @(negedge clk);
        idle_inputs();
        check("R9 mid-gate vf nonzero", int'(vf_count != 0), 1);
        delay_act = 1'b1;
        @(negedge clk);
        check("R9 abort vf", int'(vf_count), 0);
        check("R9 abort ref", int'(ref_count), 0);
        check("R9 abort done", int'(meas_done), 0);
        repeat (2) @(negedge clk);
        delay_act = 1'b0;
        run_meas("after abort R9", 4, 9, 1, 1);
    endtask

    task automatic t_saturate();
        run_meas("sat R10", 4, 9, 4, 1);           // ref 81 -> 63, vf 9
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_ref_half();
        t_cpu_slow();
        t_odd();
        t_no_edge();
        t_frozen();
        t_read();
        t_abort();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule